// File: doc/BRIEF.md
# Indirect Register Window Bridge

This block lets a host reach a large internal register space through two small windows of host registers. Each window has three host registers: a target-address register, a data register and a control register. Window A sits at host offsets 0x00/0x04/0x08 and serves the top-level control bank. Window B sits at 0x10/0x14/0x18 and serves the core-controller bank. The host first sets a target address, then reads or writes the data register. The bridge turns each data access into a transaction on an internal register bus.

The host port is a single-cycle valid/ready register bus with 32-bit data. The address register takes a new value only when the same value is written twice in a row. Reads are pipelined: the first data read returns the holding register and starts an internal fetch, and the second data read returns the fetched word. A single data write commits its value. One shared access engine serves both windows and gives window A fixed priority. Each access holds the engine for `ACC_LAT` cycles and is followed by `TURN_CYC` turnaround cycles. An address beyond a window's maximum register index is a failing access. Bit 15 of the window's control register decides whether that failure is reported on the host bus.

State machines:
- Each window has `CH_IDLE`, `CH_RD_PEND` and `CH_WR_PEND`. An in-range data write moves `CH_IDLE` to `CH_WR_PEND`. An in-range first read moves `CH_IDLE` to `CH_RD_PEND`. Engine completion moves either pending state back to `CH_IDLE`.
- The engine has `ENG_IDLE`, `ENG_RUN` and `ENG_TURN`. A pending request moves `ENG_IDLE` to `ENG_RUN`. After `ACC_LAT` cycles `ENG_RUN` moves to `ENG_TURN`, or to `ENG_IDLE` when `TURN_CYC` is 0. After `TURN_CYC` cycles `ENG_TURN` moves to `ENG_IDLE`.

Top module: `regwin_bridge`

## Requirements
- R1: After reset, both address registers and both control registers read 0, every internal register reads 0, and `rsp_valid` is low.
- R2: The host decode is offset bits [3:2] (0 = address, 1 = data, 2 = control) and bit 4 (0 = window A, 1 = window B). Bits [1:0] and every bit above bit 4 must be zero.
- R3: An address-register write commits only when it carries the same low 16 bits as the write just before it to the same window's address register. Any other access to that window in between, or a different value, restarts the pair. Only bits [15:0] are kept. Reading the address register returns the committed address.
- R4: One write to the data register commits its 32-bit value to the addressed internal register.
- R5: A data read returns the window's holding register. The first read after an address commit or a data write starts a fetch. The second read returns the word at the committed address.
- R6: `rsp_valid` goes high in the cycle after each accepted request. While a window has an internal access outstanding, `req_ready` is low for every access to that window. Accesses to the other window are accepted without delay.
- R7: Only bit 15 of a control register is writable. All other control bits read 0.
- R8: An address greater than the window's maximum index fails. With control bit 15 clear, a failing read returns 0, a failing write changes no internal register, and `rsp_err` stays 0.
- R9: With control bit 15 set, every data access at a failing address responds with `rsp_err` = 1. The data rules of R8 still apply. The maximum index itself is a valid address.
- R10: From acceptance of an access, a window stays busy for `ACC_LAT`+1 edges when the engine is idle. Each engine access is followed by `TURN_CYC` idle cycles.
- R11: When both windows have a request pending while the engine is idle, window A is served first.
- R12: The two windows hold separate address, control and bank state. Unmapped offsets read 0 with no error, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Bridge can accept the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | HOST_AW | Host byte offset |
| req_wdata | input | DW | Host write data |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata | output | DW | Read data (0 for writes) |
| rsp_err | output | 1 | Error response for a failing data access |

## Verification
The bench builds the bridge with maximum indexes of 15 for window A and 7 for window B, `ACC_LAT` = 3 and `TURN_CYC` = 2. The small banks put the first failing index, the last valid index and the aliasing of failing addresses onto in-range storage within a few writes. The turnaround gap gives time for a new window-A request to arrive while a window-B request waits. That sets up the simultaneous request, and the bench sees the priority as the exact number of stall cycles a later window-B access suffers.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int unsigned WIN_AW     = 16;
    localparam int unsigned ERR_EN_BIT = 15;

    typedef enum logic [1:0] {
        WIN_ADDR = 2'd0,
        WIN_DATA = 2'd1,
        WIN_CTRL = 2'd2,
        WIN_NONE = 2'd3
    } win_sel_e;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_RD_PEND = 2'd1,
        CH_WR_PEND = 2'd2
    } ch_state_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RUN  = 2'd1,
        ENG_TURN = 2'd2
    } eng_state_e;

endpackage

// File: rtl/regwin_channel.sv
module regwin_channel
    import regwin_pkg::*;
#(
    parameter int unsigned MAX_IDX = 15,
    parameter int unsigned DW      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  win_sel_e          sel_i,
    input  logic              wr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic              busy_o,
    output logic [DW-1:0]     rdata_o,
    output logic              err_o,
    output logic              eng_req_o,
    output logic              eng_wr_o,
    output logic [WIN_AW-1:0] eng_addr_o,
    output logic [DW-1:0]     eng_wdata_o,
    input  logic              eng_done_i,
    input  logic [DW-1:0]     eng_rdata_i
);

    localparam logic [WIN_AW-1:0] MAX_A = WIN_AW'(MAX_IDX);

    ch_state_e         state_q, state_d;
    logic [WIN_AW-1:0] addr_cur, addr_stage;
    logic              arm_q;
    logic              err_en_q;
    logic              rd_phase_q;
    logic [DW-1:0]     hold_q;
    logic [DW-1:0]     wbuf_q;
    logic              oor;
    logic              data_acc, addr_wr, ctrl_wr;
    logic [WIN_AW-1:0] addr_in;

    assign oor      = addr_cur > MAX_A;
    assign data_acc = acc_i && (sel_i == WIN_DATA);
    assign addr_wr  = acc_i && (sel_i == WIN_ADDR) && wr_i;
    assign ctrl_wr  = acc_i && (sel_i == WIN_CTRL) && wr_i;
    assign addr_in  = wdata_i[WIN_AW-1:0];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (data_acc && !oor) begin
                    if (wr_i)             state_d = CH_WR_PEND;
                    else if (!rd_phase_q) state_d = CH_RD_PEND;
                end
            end
            CH_RD_PEND, CH_WR_PEND: begin
                if (eng_done_i) state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // window registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_cur   <= '0;
            addr_stage <= '0;
            arm_q      <= 1'b0;
            err_en_q   <= 1'b0;
            rd_phase_q <= 1'b0;
            hold_q     <= '0;
            wbuf_q     <= '0;
        end else begin
            if (addr_wr) begin
                rd_phase_q <= 1'b0;
                if (arm_q && (addr_in == addr_stage)) begin
                    addr_cur <= addr_in;
                    arm_q    <= 1'b0;
                end else begin
                    addr_stage <= addr_in;
                    arm_q      <= 1'b1;
                end
            end else if (acc_i) begin
                arm_q <= 1'b0;
            end
            if (ctrl_wr) err_en_q <= wdata_i[ERR_EN_BIT];
            if (data_acc) begin
                if (wr_i) begin
                    rd_phase_q <= 1'b0;
                    wbuf_q     <= wdata_i;
                end else begin
                    rd_phase_q <= ~rd_phase_q;
                    if (!rd_phase_q && oor) hold_q <= '0;
                end
            end
            if (eng_done_i && (state_q == CH_RD_PEND)) hold_q <= eng_rdata_i;
        end
    end

    // outputs
    always_comb begin
        busy_o      = (state_q != CH_IDLE);
        eng_req_o   = busy_o;
        eng_wr_o    = (state_q == CH_WR_PEND);
        eng_addr_o  = addr_cur;
        eng_wdata_o = wbuf_q;
        err_o       = (sel_i == WIN_DATA) && oor && err_en_q;
        rdata_o     = '0;
        unique case (sel_i)
            WIN_ADDR: rdata_o = DW'(addr_cur);
            WIN_DATA: rdata_o = oor ? '0 : hold_q;
            WIN_CTRL: rdata_o = DW'({err_en_q, 15'd0});
            default:  rdata_o = '0;
        endcase
    end

    p_eng_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_o |-> (addr_cur <= MAX_A));

    p_addr_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(addr_cur));

    p_done_when_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done_i |-> busy_o);

endmodule

// File: rtl/regwin_engine.sv
module regwin_engine
    import regwin_pkg::*;
#(
    parameter int unsigned NCH      = 2,
    parameter int unsigned DW       = 32,
    parameter int unsigned ACC_LAT  = 3,
    parameter int unsigned TURN_CYC = 2,
    localparam int unsigned CH_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i   [NCH],
    input  logic              wr_i    [NCH],
    input  logic [WIN_AW-1:0] addr_i  [NCH],
    input  logic [DW-1:0]     wdata_i [NCH],
    output logic              done_o  [NCH],
    output logic [DW-1:0]     rdata_o,
    output logic              rb_en_o,
    output logic              rb_wr_o,
    output logic [CH_W-1:0]   rb_bank_o,
    output logic [WIN_AW-1:0] rb_idx_o,
    output logic [DW-1:0]     rb_wdata_o,
    input  logic [DW-1:0]     rb_rdata_i
);

    localparam int unsigned CNT_MAX   = (ACC_LAT > TURN_CYC) ? ACC_LAT : TURN_CYC;
    localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);
    localparam int unsigned RUN_LAST  = (ACC_LAT > 0) ? ACC_LAT - 1 : 0;
    localparam int unsigned TURN_LAST = (TURN_CYC > 0) ? TURN_CYC - 1 : 0;

    eng_state_e       state_q, state_d;
    logic [CH_W-1:0]  cur_ch;
    logic [CNT_W-1:0] cnt_q;
    logic [CH_W-1:0]  pick;
    logic             any_req;
    logic             run_last, turn_last;

    // fixed priority: lowest index wins
    always_comb begin
        any_req = 1'b0;
        pick    = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_req = 1'b1;
                pick    = CH_W'(i);
            end
        end
    end

    assign run_last  = (cnt_q == CNT_W'(RUN_LAST));
    assign turn_last = (cnt_q == CNT_W'(TURN_LAST));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE: if (any_req) state_d = ENG_RUN;
            ENG_RUN:  if (run_last) state_d = (TURN_CYC == 0) ? ENG_IDLE : ENG_TURN;
            ENG_TURN: if (turn_last) state_d = ENG_IDLE;
            default:  state_d = ENG_IDLE;
        endcase
    end

    // counter and grant latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ch <= '0;
            cnt_q  <= '0;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    cnt_q <= '0;
                    if (any_req) cur_ch <= pick;
                end
                ENG_RUN:  cnt_q <= run_last ? '0 : cnt_q + 1'b1;
                ENG_TURN: cnt_q <= turn_last ? '0 : cnt_q + 1'b1;
                default:  cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        rb_en_o    = (state_q == ENG_RUN) && run_last;
        rb_wr_o    = rb_en_o && wr_i[cur_ch];
        rb_bank_o  = cur_ch;
        rb_idx_o   = addr_i[cur_ch];
        rb_wdata_o = wdata_i[cur_ch];
        rdata_o    = rb_rdata_i;
        for (int i = 0; i < NCH; i++) begin
            done_o[i] = rb_en_o && (cur_ch == CH_W'(i));
        end
    end

    p_fixed_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_IDLE && req_i[0]) |=> (state_q == ENG_RUN && cur_ch == '0));

    p_access_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rb_en_o |=> !rb_en_o);

    p_served_was_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rb_en_o |-> req_i[cur_ch]);

endmodule

// File: rtl/regwin_regfile.sv
module regwin_regfile
    import regwin_pkg::*;
#(
    parameter int unsigned DW      = 32,
    parameter int unsigned DEPTH_A = 16,
    parameter int unsigned DEPTH_B = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              wr_i,
    input  logic              bank_i,
    input  logic [WIN_AW-1:0] idx_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o
);

    logic [DW-1:0] bank_rd [2];

    for (genvar gb = 0; gb < 2; gb++) begin : g_bank
        localparam int unsigned D  = (gb == 0) ? DEPTH_A : DEPTH_B;
        localparam int unsigned IW = (D > 1) ? $clog2(D) : 1;

        logic [DW-1:0] mem [D];
        logic          in_rng;
        logic          hit_wr;

        assign in_rng = idx_i < WIN_AW'(D);
        assign hit_wr = en_i && wr_i && (bank_i == 1'(gb)) && in_rng;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < D; k++) mem[k] <= '0;
            end else if (hit_wr) begin
                mem[idx_i[IW-1:0]] <= wdata_i;
            end
        end

        assign bank_rd[gb] = in_rng ? mem[idx_i[IW-1:0]] : '0;

        p_idx_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (en_i && bank_i == 1'(gb)) |-> in_rng);
    end

    assign rdata_o = bank_rd[bank_i];

endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
    import regwin_pkg::*;
#(
    parameter int unsigned HOST_AW   = 8,
    parameter int unsigned DW        = 32,
    parameter int unsigned MAX_IDX_A = 63,
    parameter int unsigned MAX_IDX_B = 31,
    parameter int unsigned ACC_LAT   = 2,
    parameter int unsigned TURN_CYC  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [HOST_AW-1:0] req_addr,
    input  logic [DW-1:0]      req_wdata,
    output logic               rsp_valid,
    output logic [DW-1:0]      rsp_rdata,
    output logic               rsp_err
);

    localparam int unsigned NCH = 2;

    logic              mapped;
    logic              tgt_ch;
    win_sel_e          sel;
    logic              accept;

    logic              ch_acc      [NCH];
    logic              ch_busy     [NCH];
    logic              ch_err      [NCH];
    logic [DW-1:0]     ch_rdata    [NCH];
    logic              eng_req     [NCH];
    logic              eng_wr      [NCH];
    logic [WIN_AW-1:0] eng_addr    [NCH];
    logic [DW-1:0]     eng_wdata   [NCH];
    logic              eng_done    [NCH];
    logic [DW-1:0]     eng_rdata;

    logic              rb_en, rb_wr, rb_bank;
    logic [WIN_AW-1:0] rb_idx;
    logic [DW-1:0]     rb_wdata, rb_rdata;

    // host decode
    always_comb begin
        mapped = (req_addr[HOST_AW-1:5] == '0) && (req_addr[1:0] == 2'b00)
                 && (req_addr[3:2] != 2'b11);
        tgt_ch = req_addr[4];
        sel    = mapped ? win_sel_e'(req_addr[3:2]) : WIN_NONE;
    end

    assign req_ready = !mapped || !ch_busy[tgt_ch];
    assign accept    = req_valid && req_ready;

    for (genvar g = 0; g < NCH; g++) begin : g_win
        assign ch_acc[g] = accept && mapped && (tgt_ch == 1'(g));

        regwin_channel #(
            .MAX_IDX (g == 0 ? MAX_IDX_A : MAX_IDX_B),
            .DW      (DW)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .acc_i       (ch_acc[g]),
            .sel_i       (sel),
            .wr_i        (req_write),
            .wdata_i     (req_wdata),
            .busy_o      (ch_busy[g]),
            .rdata_o     (ch_rdata[g]),
            .err_o       (ch_err[g]),
            .eng_req_o   (eng_req[g]),
            .eng_wr_o    (eng_wr[g]),
            .eng_addr_o  (eng_addr[g]),
            .eng_wdata_o (eng_wdata[g]),
            .eng_done_i  (eng_done[g]),
            .eng_rdata_i (eng_rdata)
        );
    end

    regwin_engine #(
        .NCH      (NCH),
        .DW       (DW),
        .ACC_LAT  (ACC_LAT),
        .TURN_CYC (TURN_CYC)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (eng_req),
        .wr_i       (eng_wr),
        .addr_i     (eng_addr),
        .wdata_i    (eng_wdata),
        .done_o     (eng_done),
        .rdata_o    (eng_rdata),
        .rb_en_o    (rb_en),
        .rb_wr_o    (rb_wr),
        .rb_bank_o  (rb_bank),
        .rb_idx_o   (rb_idx),
        .rb_wdata_o (rb_wdata),
        .rb_rdata_i (rb_rdata)
    );

    regwin_regfile #(
        .DW      (DW),
        .DEPTH_A (MAX_IDX_A + 1),
        .DEPTH_B (MAX_IDX_B + 1)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (rb_en),
        .wr_i    (rb_wr),
        .bank_i  (rb_bank),
        .idx_i   (rb_idx),
        .wdata_i (rb_wdata),
        .rdata_o (rb_rdata)
    );

    // response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= accept;
            rsp_rdata <= (accept && mapped && !req_write) ? ch_rdata[tgt_ch] : '0;
            rsp_err   <= accept && mapped && ch_err[tgt_ch];
        end
    end

    p_rsp_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready));

    p_err_only_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && $past(req_addr[3:2] == 2'b01)));

endmodule

// File: tb/regwin_bridge_test.sv
module regwin_bridge_test;

    localparam int unsigned LAT  = 3;
    localparam int unsigned TURN = 2;

    localparam logic [7:0] A_ADR = 8'h00, A_DAT = 8'h04, A_CTL = 8'h08;
    localparam logic [7:0] B_ADR = 8'h10, B_DAT = 8'h14, B_CTL = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    regwin_bridge #(
        .HOST_AW   (8),
        .DW        (32),
        .MAX_IDX_A (15),
        .MAX_IDX_B (7),
        .ACC_LAT   (LAT),
        .TURN_CYC  (TURN)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic er, output int stalls);
        logic acc;
        stalls    = 0;
        acc       = 1'b0;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        while (!acc) begin
            #1;
            acc = req_ready;
            @(posedge clk);
            @(negedge clk);
            if (!acc) stalls++;
        end
        req_valid = 1'b0;
        check("R6 response valid after accept", {31'd0, rsp_valid}, 32'd1);
        rd = rsp_rdata;
        er = rsp_err;
    endtask

    task automatic hw(input logic [7:0] a, input logic [31:0] d, output logic er);
        logic [31:0] rd;
        int s;
        access(1'b1, a, d, rd, er, s);
    endtask

    task automatic hr(input logic [7:0] a, output logic [31:0] rd, output logic er);
        int s;
        access(1'b0, a, 32'd0, rd, er, s);
    endtask

    task automatic set_addr(input logic [7:0] base, input logic [31:0] v);
        logic er;
        hw(base, v, er);
        hw(base, v, er);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] rd;
        logic er;
        check("R1 rsp_valid idle after reset", {31'd0, rsp_valid}, 32'd0);
        hr(A_ADR, rd, er); check("R1 A address reset", rd, 32'd0);
        hr(A_CTL, rd, er); check("R1 A control reset", rd, 32'd0);
        hr(B_ADR, rd, er); check("R1 B address reset", rd, 32'd0);
        hr(B_CTL, rd, er); check("R1 B control reset", rd, 32'd0);
        set_addr(A_ADR, 32'd9);
        hr(A_DAT, rd, er); hr(A_DAT, rd, er);
        check("R1 internal register reset", rd, 32'd0);
    endtask

    task automatic t_write_read;
        logic [31:0] rd;
        logic er;
        set_addr(A_ADR, 32'd3); hw(A_DAT, 32'h1111_2222, er);
        set_addr(B_ADR, 32'd3); hw(B_DAT, 32'h3333_4444, er);
        set_addr(A_ADR, 32'd5); hw(A_DAT, 32'hAAAA_0005, er);
        set_addr(A_ADR, 32'd3);
        hr(A_DAT, rd, er); hr(A_DAT, rd, er);
        check("R4 A idx3 write then read", rd, 32'h1111_2222);
        set_addr(B_ADR, 32'd3);
        hr(B_DAT, rd, er); hr(B_DAT, rd, er);
        check("R12 B bank separate from A", rd, 32'h3333_4444);
        set_addr(A_ADR, 32'd5);
        hr(A_DAT, rd, er);
        check("R5 first read returns stale holding", rd, 32'h1111_2222);
        hr(A_DAT, rd, er);
        check("R5 second read returns addressed word", rd, 32'hAAAA_0005);
    endtask

    task automatic t_addr_capture;
        logic [31:0] rd;
        logic er;
        set_addr(A_ADR, 32'd2);
        hw(A_ADR, 32'd9, er);
        hr(A_ADR, rd, er); check("R3 single address write not committed", rd, 32'd2);
        hw(A_ADR, 32'd9, er); hw(A_ADR, 32'd9, er);
        hr(A_ADR, rd, er); check("R3 double address write commits", rd, 32'd9);
        set_addr(A_ADR, 32'h1234_0006);
        hr(A_ADR, rd, er); check("R3 only low 16 bits kept", rd, 32'd6);
        hw(A_ADR, 32'd4, er); hr(A_CTL, rd, er); hw(A_ADR, 32'd4, er);
        hr(A_ADR, rd, er); check("R3 intervening access restarts pair", rd, 32'd6);
        hw(A_ADR, 32'd4, er); hw(A_ADR, 32'd7, er); hw(A_ADR, 32'd7, er);
        hr(A_ADR, rd, er); check("R3 differing value restarts pair", rd, 32'd7);
        hr(B_ADR, rd, er); check("R12 B address untouched by A", rd, 32'd3);
    endtask

    task automatic t_ctrl;
        logic [31:0] rd;
        logic er;
        hw(A_CTL, 32'hFFFF_FFFF, er);
        hr(A_CTL, rd, er); check("R7 only bit 15 writable", rd, 32'h0000_8000);
        hr(B_CTL, rd, er); check("R12 B control separate", rd, 32'd0);
        hw(A_CTL, 32'd0, er);
        hr(A_CTL, rd, er); check("R7 bit 15 clears", rd, 32'd0);
    endtask

    task automatic t_oor_quiet;
        logic [31:0] rd;
        logic er;
        set_addr(A_ADR, 32'd20);
        hw(A_DAT, 32'hDEAD_BEEF, er); check("R8 failing write no error", {31'd0, er}, 32'd0);
        hr(A_DAT, rd, er); hr(A_DAT, rd, er);
        check("R8 failing read returns zero", rd, 32'd0);
        check("R8 failing read no error", {31'd0, er}, 32'd0);
        set_addr(A_ADR, 32'd4);
        hr(A_DAT, rd, er); hr(A_DAT, rd, er);
        check("R8 failing write dropped (alias idx4)", rd, 32'd0);
    endtask

    task automatic t_oor_err;
        logic [31:0] rd;
        logic er;
        hw(A_CTL, 32'h0000_8000, er);
        set_addr(A_ADR, 32'd16);
        hw(A_DAT, 32'h5A5A_5A5A, er); check("R9 failing write error", {31'd0, er}, 32'd1);
        hr(A_DAT, rd, er); check("R9 failing read error", {31'd0, er}, 32'd1);
        hr(A_DAT, rd, er); check("R9 failing read returns zero", rd, 32'd0);
        set_addr(A_ADR, 32'd15);
        hw(A_DAT, 32'hF00D_000F, er); check("R9 max index write no error", {31'd0, er}, 32'd0);
        hr(A_DAT, rd, er); hr(A_DAT, rd, er);
        check("R9 max index readable", rd, 32'hF00D_000F);
        check("R9 max index read no error", {31'd0, er}, 32'd0);
        set_addr(A_ADR, 32'd0);
        hr(A_DAT, rd, er); hr(A_DAT, rd, er);
        check("R9 failing write dropped (alias idx0)", rd, 32'd0);
        set_addr(B_ADR, 32'd8);
        hr(B_DAT, rd, er); check("R12 B error disabled independently", {31'd0, er}, 32'd0);
        hr(B_DAT, rd, er);
        hw(A_CTL, 32'd0, er);
    endtask

    task automatic t_unmapped;
        logic [31:0] rd;
        logic er;
        hr(8'h0C, rd, er); check("R12 unmapped read zero", rd, 32'd0);
        check("R12 unmapped no error", {31'd0, er}, 32'd0);
        hw(8'h20, 32'd11, er); hw(8'h20, 32'd11, er);
        hw(8'h02, 32'd11, er); hw(8'h02, 32'd11, er);
        hr(8'h24, rd, er); check("R2 high offset bits unmapped", rd, 32'd0);
        hr(A_ADR, rd, er); check("R2 unmapped writes ignored", rd, 32'd0);
    endtask

    task automatic t_stall;
        logic [31:0] rd;
        logic er;
        int s;
        set_addr(A_ADR, 32'd1);
        idle(10);
        access(1'b1, A_DAT, 32'h0000_00A1, rd, er, s);
        access(1'b0, B_CTL, 32'd0, rd, er, s);
        check("R6 other window not stalled", s, 32'd0);
        access(1'b0, A_DAT, 32'd0, rd, er, s);
        check("R10 busy window stall length", s, LAT);
        access(1'b0, A_DAT, 32'd0, rd, er, s);
        check("R4 stalled write committed", rd, 32'h0000_00A1);
    endtask

    task automatic t_prio;
        logic [31:0] rd;
        logic er;
        int s;
        set_addr(A_ADR, 32'd2);
        set_addr(B_ADR, 32'd2);
        idle(10);
        access(1'b1, A_DAT, 32'h0000_A002, rd, er, s);
        access(1'b1, B_DAT, 32'h0000_B002, rd, er, s);
        idle(3);
        access(1'b1, A_DAT, 32'h0000_A012, rd, er, s);
        check("R10 window free after access and gap", s, 32'd0);
        access(1'b0, B_DAT, 32'd0, rd, er, s);
        check("R11 window A served first on tie", s, 2 * (LAT + TURN) + 1);
        hr(B_DAT, rd, er);
        check("R11 B write applied", rd, 32'h0000_B002);
        hr(A_DAT, rd, er); hr(A_DAT, rd, er);
        check("R11 A write applied", rd, 32'h0000_A012);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_addr_capture();
        t_ctrl();
        t_oor_quiet();
        t_oor_err();
        t_unmapped();
        t_stall();
        t_prio();
        idle(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule